// File: doc/BRIEF.md
# Gapless Shift-Register Byte Streamer

This block feeds an external serial-in, parallel-out register of the common 595 style. It needs only three wires: a serial clock, a serial data line and a storage-latch line. All three come from one system clock. The serial clock runs at half the system clock. Bytes arrive on a valid/ready stream and are shifted out MSB first.

A start pulse loads a byte count, and the block then sends that many bytes back to back. The latch edge that moves each finished byte to the external outputs is placed in the one-cycle gap between the last rising clock edge of that byte and the first rising edge of the next. No idle clock period or turnaround is needed between bytes, so a continuous stream moves one byte every eight serial clock periods. When the count is used up, the block pulses `donePulse` and returns to idle.

Top module: `gapless_shift_streamer`

## Requirements
- R1: After reset and whenever idle, `sckOut` is low, `latchOut` is high, `busy` is low, `donePulse` is low and `inReady` is low.
- R2: While shifting, `sckOut` is high for exactly one system clock cycle and low for at least one cycle, so a bit period is two system cycles.
- R3: Bits leave MSB first. `sdoOut` changes only in a cycle in which `sckOut` is low, and never at the edge that raises `sckOut`.
- R4: Every rising edge of `latchOut` follows exactly 8 rising edges of `sckOut` since the run started or since the previous latch edge. The latch edge falls in the cycle in which `sckOut` falls after bit 7, which is one cycle after the last rising edge and one cycle before the next byte's first rising edge.
- R5: Once a run is under way, each latch pulse stays high for exactly two system cycles and then goes low. After the final byte, `latchOut` stays high.
- R6: With the input stream valid at all times, consecutive latch rising edges are exactly 16 system cycles apart.
- R7: `inReady` is high only while busy: during the high half of bit 7 when more bytes remain, or while waiting for a byte. The block never takes more bytes than the programmed count.
- R8: If no byte is valid when one is needed, `sckOut` stays low and the latch still fires for the completed byte. Shifting resumes once data arrives, and no counted byte is lost or duplicated.
- R9: Exactly `byteCount` latch edges occur per run. `donePulse` is high for one cycle, one cycle after the final latch rising edge, and `busy` is low in that same cycle.
- R10: A start with `byteCount` of zero raises `donePulse` in the next cycle, produces no `sckOut` edge, and leaves `busy` low.
- R11: A start pulse while busy is ignored: the run in progress keeps its count and produces one done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| startPulse | input | 1 | Starts a run when idle |
| byteCount | input | COUNT_W | Number of bytes in the run, sampled at start |
| inData | input | DATA_W | Stream data byte |
| inValid | input | 1 | Stream data valid |
| inReady | output | 1 | Block takes `inData` at this edge when valid |
| sckOut | output | 1 | Serial clock to the external register |
| sdoOut | output | 1 | Serial data, MSB first |
| latchOut | output | 1 | Storage latch; its rising edge transfers the byte |
| busy | output | 1 | A run is in progress |
| donePulse | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench models the external register: it shifts `sdoOut` in on each observed rising `sckOut` edge and captures the byte on each latch rising edge. A latch edge placed one cycle early or late therefore shows up as a wrong captured byte, a wrong bit count, or a latch edge that coincides with a clock edge. With the stream held valid, a stall or idle period between bytes breaks the fixed 16-cycle spacing of latch edges. Stream gaps longer than a byte check that a starved block holds the clock low and still latches the finished byte; a design that waited for the next byte, or dropped one, would capture a shifted sequence. The bench also looks for misbehaviour at the edges of a run: a zero count that clocks anyway, a start during a run that reloads the count, a done pulse that comes one cycle off, and a source offering more bytes than the count that is drained too far.

// File: rtl/streamer_pkg.sv
package streamer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SHIFT,
    ST_DRAIN
  } streamState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic loadByte;  // capture inData, drive its MSB, clock low
    logic riseSck;   // raise the serial clock
    logic nextBit;   // lower the clock and present the next bit
    logic endByte;   // lower the clock and raise the latch
    logic holdHigh;  // keep the latch high once its pulse has run out
  } dpStrobe_t;

endpackage

// File: rtl/streamer_ctrl.sv
module streamer_ctrl
  import streamer_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               startPulse,
  input  logic [COUNT_W-1:0] byteCount,
  input  logic               inValid,
  output logic               inReady,
  output logic               busy,
  output logic               donePulse,
  output dpStrobe_t          strobe
);

  localparam int BIT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  streamState_t       state;
  logic [BIT_W-1:0]   bitIdx;
  logic               phaseHi;
  logic [COUNT_W-1:0] bytesLeft;

  logic lastBit;
  logic moreAfter;
  logic inShift;
  logic accept;

  assign lastBit   = (bitIdx == LAST_BIT);
  assign moreAfter = (bytesLeft != COUNT_W'(1));
  assign inShift   = (state == ST_SHIFT);

  // ask for the next byte only in the high half of the final bit
  assign inReady = (state == ST_FETCH) ||
                   (inShift && phaseHi && lastBit && moreAfter);
  assign accept  = inValid && inReady;
  assign busy    = (state != ST_IDLE);

  always_comb begin
    strobe          = '0;
    strobe.loadByte = accept;
    strobe.riseSck  = inShift && !phaseHi;
    strobe.nextBit  = inShift && phaseHi && !lastBit;
    strobe.endByte  = inShift && phaseHi && lastBit;
    strobe.holdHigh = (state == ST_IDLE) || (state == ST_DRAIN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bitIdx    <= '0;
      phaseHi   <= 1'b0;
      bytesLeft <= '0;
      donePulse <= 1'b0;
    end else begin
      donePulse <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (startPulse) begin
            if (byteCount == '0) begin
              donePulse <= 1'b1;
            end else begin
              bytesLeft <= byteCount;
              state     <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (inValid) begin
            bitIdx  <= '0;
            phaseHi <= 1'b0;
            state   <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (!phaseHi) begin
            phaseHi <= 1'b1;
          end else if (!lastBit) begin
            bitIdx  <= bitIdx + BIT_W'(1);
            phaseHi <= 1'b0;
          end else begin
            bytesLeft <= bytesLeft - COUNT_W'(1);
            bitIdx    <= '0;
            phaseHi   <= 1'b0;
            if (!moreAfter) begin
              state <= ST_DRAIN;
            end else if (!inValid) begin
              state <= ST_FETCH;
            end
          end
        end
        ST_DRAIN: begin
          donePulse <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/streamer_datapath.sv
module streamer_datapath
  import streamer_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LATCH_HIGH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] inData,
  output logic              sckOut,
  output logic              sdoOut,
  output logic              latchOut
);

  localparam int HOLD_W = $clog2(LATCH_HIGH + 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(LATCH_HIGH - 1);

  logic [DATA_W-1:0] shiftReg;
  logic [HOLD_W-1:0] holdCnt;

  // serial data: the MSB goes out first, then one bit per falling clock
  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      sdoOut   <= 1'b0;
    end else if (strobe.loadByte) begin
      shiftReg <= inData;
      sdoOut   <= inData[DATA_W-1];
    end else if (strobe.nextBit) begin
      shiftReg <= shiftReg << 1;
      sdoOut   <= shiftReg[DATA_W-2];
    end
  end

  // serial clock at half the system rate
  always_ff @(posedge clk) begin
    if (rst) begin
      sckOut <= 1'b0;
    end else if (strobe.riseSck) begin
      sckOut <= 1'b1;
    end else if (strobe.nextBit || strobe.endByte || strobe.loadByte) begin
      sckOut <= 1'b0;
    end
  end

  // latch: rises together with the clock fall after the last bit
  always_ff @(posedge clk) begin
    if (rst) begin
      latchOut <= 1'b1;
      holdCnt  <= '0;
    end else if (strobe.endByte) begin
      latchOut <= 1'b1;
      holdCnt  <= HOLD_LOAD;
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - HOLD_W'(1);
    end else if (!strobe.holdHigh) begin
      latchOut <= 1'b0;
    end
  end

endmodule

// File: rtl/gapless_shift_streamer.sv
module gapless_shift_streamer
  import streamer_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int COUNT_W    = 8,
  parameter int LATCH_HIGH = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               startPulse,
  input  logic [COUNT_W-1:0] byteCount,
  input  logic [DATA_W-1:0]  inData,
  input  logic               inValid,
  output logic               inReady,
  output logic               sckOut,
  output logic               sdoOut,
  output logic               latchOut,
  output logic               busy,
  output logic               donePulse
);

  dpStrobe_t strobe;

  streamer_ctrl #(
    .DATA_W (DATA_W),
    .COUNT_W(COUNT_W)
  ) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .startPulse(startPulse),
    .byteCount (byteCount),
    .inValid   (inValid),
    .inReady   (inReady),
    .busy      (busy),
    .donePulse (donePulse),
    .strobe    (strobe)
  );

  streamer_datapath #(
    .DATA_W    (DATA_W),
    .LATCH_HIGH(LATCH_HIGH)
  ) i_datapath (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .inData  (inData),
    .sckOut  (sckOut),
    .sdoOut  (sdoOut),
    .latchOut(latchOut)
  );

endmodule

// File: rtl/streamer_checker.sv
module streamer_checker (
  input logic clk,
  input logic rst,
  input logic sckOut,
  input logic sdoOut,
  input logic latchOut,
  input logic busy,
  input logic donePulse,
  input logic inReady
);

  assert_idle_sck_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sckOut);

  assert_sck_half_R2: assert property (@(posedge clk) disable iff (rst)
    sckOut |=> !sckOut);

  assert_sdo_setup_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(sckOut) |-> $stable(sdoOut));

  assert_latch_window_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(latchOut) |-> $fell(sckOut));

  assert_ready_busy_R7: assert property (@(posedge clk) disable iff (rst)
    inReady |-> busy);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    donePulse |-> (!busy && latchOut) ##1 !donePulse);

endmodule

bind gapless_shift_streamer streamer_checker i_checker (
  .clk      (clk),
  .rst      (rst),
  .sckOut   (sckOut),
  .sdoOut   (sdoOut),
  .latchOut (latchOut),
  .busy     (busy),
  .donePulse(donePulse),
  .inReady  (inReady)
);

// File: tb/test_gapless_shift_streamer.sv
`timescale 1ns/1ps
module test_gapless_shift_streamer;

  localparam int DW = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst;
  logic startPulse;
  logic [CW-1:0] byteCount;
  logic [DW-1:0] inData;
  logic inValid;
  logic inReady, sckOut, sdoOut, latchOut, busy, donePulse;

  always #2 clk = ~clk;

  gapless_shift_streamer #(.DATA_W(DW), .COUNT_W(CW)) i_gapless_shift_streamer (
    .clk(clk), .rst(rst), .startPulse(startPulse), .byteCount(byteCount),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .sckOut(sckOut), .sdoOut(sdoOut), .latchOut(latchOut),
    .busy(busy), .donePulse(donePulse)
  );

  int checks = 0;
  int failures = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- external register model ----------------
  int cyc = 0;
  logic prevSck = 1'b0, prevLatch = 1'b1;
  logic [7:0] sr = '0;
  int bitsSinceLatch, capCount, sckRiseCount, latchRiseCyc, lastRiseCyc;
  int latchBitErr, windowErr, highLenErr, sckHighErr, doneCount, doneCyc, doneBusyErr;
  logic [7:0] cap [0:255];
  int latchCyc [0:255];

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (sckOut && prevSck) sckHighErr++;
      if (sckOut && !prevSck) begin
        sr = {sr[6:0], sdoOut};
        bitsSinceLatch++;
        sckRiseCount++;
        lastRiseCyc = cyc;
      end
      if (latchOut && !prevLatch) begin
        if (bitsSinceLatch != 8) latchBitErr++;
        if (cyc == lastRiseCyc) windowErr++;
        if (capCount < 256) begin
          cap[capCount] = sr;
          latchCyc[capCount] = cyc;
        end
        capCount++;
        bitsSinceLatch = 0;
        latchRiseCyc = cyc;
      end
      if (!latchOut && prevLatch && capCount > 0 && (cyc - latchRiseCyc) != 2)
        highLenErr++;
      if (donePulse) begin
        doneCount++;
        doneCyc = cyc;
        if (busy) doneBusyErr++;
      end
      prevSck = sckOut;
      prevLatch = latchOut;
    end
  end

  task automatic clearMon();
    bitsSinceLatch = 0; capCount = 0; sckRiseCount = 0; latchRiseCyc = -10;
    lastRiseCyc = -10; latchBitErr = 0; windowErr = 0; highLenErr = 0;
    sckHighErr = 0; doneCount = 0; doneCyc = 0; doneBusyErr = 0;
  endtask

  // ---------------- stream source ----------------
  logic [7:0] srcData [0:255];
  int srcLen = 0, srcIdx = 0, gapLen = 0, gapCnt = 0;
  bit hsPending = 0;

  always @(negedge clk) begin
    if (hsPending) begin
      srcIdx++;
      gapCnt = gapLen;
    end
    if (gapCnt > 0) begin
      inValid = 1'b0;
      gapCnt--;
    end else if (srcIdx < srcLen) begin
      inValid = 1'b1;
      inData = srcData[srcIdx];
    end else begin
      inValid = 1'b0;
    end
    hsPending = inValid && inReady;
  end

  // start one run and wait for its done pulse
  task automatic runStream(input int n, input int count, input int gap, input int seed,
                           input int midStart);
    @(negedge clk);
    for (int i = 0; i < 256; i++) srcData[i] = 8'((i * 37 + seed) ^ 8'hA5);
    srcData[0] = 8'h80;
    srcData[1] = 8'h01;
    srcLen = n; srcIdx = 0; gapLen = gap; gapCnt = 0;
    clearMon();
    @(negedge clk);
    startPulse = 1'b1;
    byteCount = CW'(count);
    @(negedge clk);
    startPulse = 1'b0;
    check(busy == 1'b1, "R9", "busy after start", int'(busy), 1);
    for (int k = 0; k < 20000 && doneCount == 0; k++) begin
      @(negedge clk);
      if (midStart != 0 && k == midStart) begin
        startPulse = 1'b1;
        byteCount = CW'(9);
      end else begin
        startPulse = 1'b0;
      end
    end
    startPulse = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic checkCommon(input int count, input string tag);
    int bad = 0;
    check(capCount == count, "R9", {tag, " latch count"}, capCount, count);
    for (int i = 0; i < count && i < 256; i++) if (cap[i] != srcData[i]) bad++;
    check(bad == 0, "R3", {tag, " captured byte mismatches"}, bad, 0);
    check(latchBitErr == 0, "R4", {tag, " latch not after 8 clocks"}, latchBitErr, 0);
    check(windowErr == 0, "R4", {tag, " latch edge on clock edge"}, windowErr, 0);
    check(highLenErr == 0, "R5", {tag, " latch high length"}, highLenErr, 0);
    check(sckHighErr == 0, "R2", {tag, " clock high >1 cycle"}, sckHighErr, 0);
    check(sckRiseCount == 8 * count, "R2", {tag, " clock rises"}, sckRiseCount, 8 * count);
    check(doneCount == 1, "R9", {tag, " done pulses"}, doneCount, 1);
    if (count > 0)
      check(doneCyc == latchCyc[count-1] + 1, "R9", {tag, " done cycle"},
            doneCyc, latchCyc[count-1] + 1);
    check(doneBusyErr == 0, "R9", {tag, " busy during done"}, doneBusyErr, 0);
    check(latchOut == 1'b1 && busy == 1'b0, "R5", {tag, " idle latch high"},
          int'(latchOut), 1);
  endtask

  task automatic testReset();
    check(sckOut == 1'b0, "R1", "reset sck", int'(sckOut), 0);
    check(latchOut == 1'b1, "R1", "reset latch", int'(latchOut), 1);
    check(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
    check(donePulse == 1'b0, "R1", "reset done", int'(donePulse), 0);
    check(inReady == 1'b0, "R1", "reset ready", int'(inReady), 0);
  endtask

  task automatic testGapless(input int n, input string tag);
    int gapBad = 0;
    runStream(n, n, 0, n, 0);
    checkCommon(n, tag);
    for (int i = 1; i < n; i++) if (latchCyc[i] - latchCyc[i-1] != 16) gapBad++;
    check(gapBad == 0, "R6", {tag, " latch spacing not 16"}, gapBad, 0);
    check(srcIdx == n, "R7", {tag, " bytes taken"}, srcIdx, n);
  endtask

  task automatic testStall();
    int longGaps = 0;
    runStream(5, 5, 25, 3, 0);
    checkCommon(5, "stall");
    for (int i = 1; i < 5; i++) if (latchCyc[i] - latchCyc[i-1] > 16) longGaps++;
    check(longGaps == 4, "R8", "stalled byte spacing", longGaps, 4);
    check(srcIdx == 5, "R8", "bytes taken while stalled", srcIdx, 5);
  endtask

  task automatic testZero();
    @(negedge clk);
    srcLen = 4; srcIdx = 0; gapLen = 0; gapCnt = 0;
    clearMon();
    startPulse = 1'b1;
    byteCount = '0;
    @(negedge clk);
    startPulse = 1'b0;
    check(donePulse == 1'b1, "R10", "zero count done", int'(donePulse), 1);
    check(busy == 1'b0, "R10", "zero count busy", int'(busy), 0);
    repeat (20) @(negedge clk);
    check(sckRiseCount == 0, "R10", "zero count clock edges", sckRiseCount, 0);
    check(srcIdx == 0, "R10", "zero count bytes taken", srcIdx, 0);
    srcLen = 0;
  endtask

  task automatic testBusyStart();
    runStream(6, 3, 0, 11, 10);
    checkCommon(3, "busy-start");
    check(srcIdx == 3, "R11", "bytes taken with start while busy", srcIdx, 3);
    check(doneCount == 1, "R11", "single done with start while busy", doneCount, 1);
  endtask

  initial begin
    rst = 1'b1;
    startPulse = 1'b0;
    byteCount = '0;
    inData = '0;
    inValid = 1'b0;
    clearMon();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testGapless(6, "gapless");
    testStall();
    testZero();
    testBusyStart();
    testGapless(240, "long");
    testReset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule